// File: doc/BRIEF.md
# Shared Free-Running Timer with Banked Per-Core Compare Interrupts

This block holds one 64-bit up-counter that two processor cores share, plus one 64-bit comparator per core. The counter advances by one on each cycle where the tick enable input is high. In the target system that enable pulses on one core-clock cycle in four. Each comparator raises a sticky event when the counter reaches its compare value. That event drives an interrupt line that only the owning core receives. In an optional auto-increment mode, each match moves the compare value forward by a programmed step, so the interrupt repeats at a fixed period while the counter keeps running.

Software reaches the block through a plain word-addressed register port. A core-select input picks which core's comparator bank the bank registers refer to. The counter is read as two 32-bit halves. Software reads high, then low, then high again, and retries if the high half changed. The counter can be given a start value exactly once after reset, and only through secure access. All interrupts carry the same banked identifier, 27, which the block presents on a constant output. There is no streaming data path, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `shared_cmp_timer`

## Requirements
- R1: After reset the counter is 0. It rises by exactly one at the clock edge of each cycle with `tick_en` high, and holds its value on all other cycles.
- R2: Raising or holding a compare event never stops, reloads or resets the counter.
- R3: A secure read at word 0 returns counter bits 31:0, and at word 1 returns bits 63:32. A carry out of the low half shows up in the high half at the same edge.
- R4: A secure write to word 0 stages a low half. A following secure write to word 1 loads the counter with {written word, staged low half}. Only the first such load after reset takes effect. Non-secure writes to words 0 and 1 are ignored and do not use up the load.
- R5: A non-secure read of word 0 or word 1 returns 0.
- R6: Words 2 to 6 select the comparator bank of the core numbered by `bus_core`. Writes to one bank leave the other bank unchanged.
- R7: Word 2 is the control register: bit0 compare enable, bit1 interrupt enable, bit2 auto-increment enable. On a tick with compare enable set, the core's event flag sets at the same edge if the counter's new value is greater than or equal to the compare value (word 4 low half, word 5 high half, reset 0). It does not set when the new value is below the compare value.
- R8: The event flag is bit0 of word 3. It stays set until software writes 1 to bit0 of word 3. Writing 0 has no effect, and a match in the same cycle wins over the clear.
- R9: `irq_o[c]` is high exactly when core c's event flag and interrupt enable are both set.
- R10: With auto-increment enabled, each match adds the 32-bit step from word 6, zero-extended, to the compare value.
- R11: `irq_id_o` always presents the interrupt identifier 27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick_en | input | 1 | counter advance enable, one cycle in four |
| bus_core | input | 1 | selects the comparator bank |
| bus_secure | input | 1 | access is secure |
| bus_wr | input | 1 | write strobe |
| bus_addr | input | 3 | word index |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | combinational read data |
| irq_o | output | 2 | per-core interrupt |
| irq_id_o | output | 5 | banked interrupt identifier |

## Verification
Some properties are checked on every cycle. The counter holds between ticks and steps by one on each tick. Once loaded, it changes only by those steps. A match always leaves the event flag set, and the flag stays set until it is cleared. An auto-increment match adds exactly one step to the compare value. Other behaviours only the bench scenarios can show. These are the once-only load and its secure gating, the zeroed non-secure reads, and the carry into the high half. They also include bank isolation between the cores, the interrupt mask against a pending flag, and the exact tick on which a periodic interrupt comes back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    IDX_CNT_LO = 3'd0,
    IDX_CNT_HI = 3'd1,
    IDX_CTRL   = 3'd2,
    IDX_STAT   = 3'd3,
    IDX_CMP_LO = 3'd4,
    IDX_CMP_HI = 3'd5,
    IDX_STEP   = 3'd6
  } reg_idx_t;

  typedef struct packed {
    logic auto_en;
    logic irq_en;
    logic cmp_en;
  } cmp_ctrl_t;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o,
  output logic              adv_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] stage_q;
  logic              loaded_q;
  logic              load_fire;

  assign load_fire = wr_hi_i & ~loaded_q;
  assign adv_o     = tick_i & ~load_fire;
  assign cnt_nxt_o = cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stage_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (wr_lo_i && !loaded_q) stage_q <= wdata_i;
      if (load_fire) begin
        cnt_q    <= {wdata_i, stage_q};
        loaded_q <= 1'b1;
      end else if (adv_o) begin
        cnt_q <= cnt_nxt_o;
      end
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_hi_i) |=> $stable(cnt_q));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_load_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp
  import tmr_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o
);
  cmp_ctrl_t         ctrl_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [HALF_W-1:0] step_q;
  logic              evt_q;
  logic              hit, cmp_wr, clr;

  assign hit    = adv_i & ctrl_q.cmp_en & (cnt_nxt_i >= cmp_q);
  assign cmp_wr = wr_i & ((addr_i == IDX_CMP_LO) | (addr_i == IDX_CMP_HI));
  assign clr    = wr_i & (addr_i == IDX_STAT) & wdata_i[0];
  assign irq_o  = evt_q & ctrl_q.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      step_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == IDX_CTRL) ctrl_q <= cmp_ctrl_t'(wdata_i[2:0]);
      if (wr_i && addr_i == IDX_STEP) step_q <= wdata_i;
      if (wr_i && addr_i == IDX_CMP_LO)      cmp_q[HALF_W-1:0]     <= wdata_i;
      else if (wr_i && addr_i == IDX_CMP_HI) cmp_q[CNT_W-1:HALF_W] <= wdata_i;
      else if (hit && ctrl_q.auto_en)        cmp_q <= cmp_q + CNT_W'(step_q);
      if (hit)      evt_q <= 1'b1;
      else if (clr) evt_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IDX_CTRL:   rdata_o = HALF_W'(ctrl_q);
      IDX_STAT:   rdata_o = HALF_W'(evt_q);
      IDX_CMP_LO: rdata_o = cmp_q[HALF_W-1:0];
      IDX_CMP_HI: rdata_o = cmp_q[CNT_W-1:HALF_W];
      IDX_STEP:   rdata_o = step_q;
      default:    rdata_o = '0;
    endcase
  end

  p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_q);
  p_rise_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(ctrl_q.cmp_en && adv_i));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !clr) |=> evt_q);
  p_auto_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl_q.auto_en && !cmp_wr) |=> (cmp_q == $past(cmp_q) + CNT_W'($past(step_q))));
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
  import tmr_pkg::*;
#(
  parameter int HALF_W  = 32,
  parameter int N_CORES = 2,
  parameter int ID_W    = 5,
  parameter int IRQ_ID  = 27,
  localparam int CNT_W  = 2 * HALF_W,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CORE_W-1:0] bus_core,
  input  logic              bus_secure,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic [N_CORES-1:0] irq_o,
  output logic [ID_W-1:0]   irq_id_o
);
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              adv;
  logic              sec_wr;
  logic [HALF_W-1:0] bank_rd [N_CORES];

  assign sec_wr   = bus_wr & bus_secure;
  assign irq_id_o = ID_W'(IRQ_ID);

  tmr_count #(.HALF_W(HALF_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_en),
    .wr_lo_i   (sec_wr & (bus_addr == IDX_CNT_LO)),
    .wr_hi_i   (sec_wr & (bus_addr == IDX_CNT_HI)),
    .wdata_i   (bus_wdata),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .adv_o     (adv)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_bank
    tmr_cmp #(.HALF_W(HALF_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .cnt_nxt_i (cnt_nxt),
      .wr_i      (bus_wr & (bus_core == CORE_W'(g))),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .rdata_o   (bank_rd[g]),
      .irq_o     (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == IDX_CNT_LO)      bus_rdata = bus_secure ? cnt[HALF_W-1:0] : '0;
    else if (bus_addr == IDX_CNT_HI) bus_rdata = bus_secure ? cnt[CNT_W-1:HALF_W] : '0;
    else if (int'(bus_core) < N_CORES) bus_rdata = bank_rd[bus_core];
  end

  p_run_on_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (|irq_o)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/shared_cmp_timer_tb_top.sv
module shared_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [0:0]  bus_core = '0;
  logic        bus_secure = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;
  logic [4:0]  irq_id_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] exp_cnt = '0;
  logic [63:0] base;
  logic [31:0] rd;

  always #10 clk = ~clk;

  shared_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_core(bus_core),
    .bus_secure(bus_secure), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_id_o(irq_id_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic core, input logic sec, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_core = core; bus_secure = sec; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdw(input logic core, input logic sec, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_core = core; bus_secure = sec; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_cnt = exp_cnt + 1;
    end
  endtask

  task automatic t_reset;
    rdw(0, 1, 3'd0, rd); check("R1 reset count lo", rd, 0);
    rdw(0, 1, 3'd3, rd); check("R8 reset event", rd, 0);
    check("R9 reset irq", irq_o, 0);
    check("R11 irq id", irq_id_o, 27);
  endtask

  task automatic t_count;
    ticks(5);
    rdw(0, 1, 3'd0, rd); check("R1 five ticks", rd, 5);
    repeat (7) @(negedge clk);
    rdw(0, 1, 3'd0, rd); check("R1 hold without tick", rd, 5);
    rdw(0, 0, 3'd0, rd); check("R5 nonsecure lo", rd, 0);
    rdw(0, 0, 3'd1, rd); check("R5 nonsecure hi", rd, 0);
  endtask

  task automatic t_load_carry;
    wr(0, 0, 3'd0, 32'h1234_5678);
    wr(0, 0, 3'd1, 32'h0000_00AA);
    rdw(0, 1, 3'd1, rd); check("R4 nonsecure load ignored", rd, 0);
    wr(0, 1, 3'd0, 32'hFFFF_FFFE);
    wr(0, 1, 3'd1, 32'h0);
    exp_cnt = 64'h0000_0000_FFFF_FFFE;
    rdw(0, 1, 3'd0, rd); check("R4 secure load lo", rd, 32'hFFFF_FFFE);
    ticks(2);
    rdw(0, 1, 3'd1, rd); check("R3 carry hi", rd, 1);
    rdw(0, 1, 3'd0, rd); check("R3 carry lo", rd, 0);
    wr(0, 1, 3'd0, 32'h55);
    wr(0, 1, 3'd1, 32'h77);
    rdw(0, 1, 3'd1, rd); check("R4 second load ignored hi", rd, 1);
    rdw(0, 1, 3'd0, rd); check("R4 second load ignored lo", rd, 0);
  endtask

  task automatic t_match;
    base = exp_cnt + 3;
    wr(0, 1, 3'd4, base[31:0]);
    wr(0, 1, 3'd5, base[63:32]);
    wr(0, 1, 3'd2, 32'h3);
    ticks(2);
    rdw(0, 1, 3'd3, rd); check("R7 below compare no event", rd, 0);
    ticks(1);
    rdw(0, 1, 3'd3, rd); check("R7 reach sets event", rd, 1);
    check("R9 irq core0 only", irq_o, 2'b01);
    ticks(1);
    rdw(0, 1, 3'd0, rd); check("R2 count continues", rd, exp_cnt[31:0]);
    wr(0, 1, 3'd3, 32'h0);
    rdw(0, 1, 3'd3, rd); check("R8 write 0 keeps event", rd, 1);
    wr(0, 1, 3'd3, 32'h1);
    rdw(0, 1, 3'd3, rd); check("R8 write 1 clears", rd, 0);
    check("R9 irq drops on clear", irq_o, 0);
    wr(0, 1, 3'd2, 32'h0);
  endtask

  task automatic t_mask_bank;
    wr(1, 0, 3'd2, 32'h1);
    ticks(1);
    rdw(1, 0, 3'd3, rd); check("R7 compare below count fires", rd, 1);
    check("R9 masked irq", irq_o, 0);
    rdw(0, 0, 3'd3, rd); check("R6 core0 untouched", rd, 0);
    wr(1, 0, 3'd2, 32'h3);
    check("R9 unmask irq core1", irq_o, 2'b10);
    rdw(0, 0, 3'd2, rd); check("R6 core0 ctrl", rd, 0);
    rdw(1, 0, 3'd2, rd); check("R6 core1 ctrl", rd, 3);
    rdw(0, 0, 3'd4, rd); check("R6 core0 cmp lo", rd, 3);
    rdw(1, 0, 3'd4, rd); check("R6 core1 cmp lo", rd, 0);
    wr(1, 0, 3'd2, 32'h0);
    wr(1, 0, 3'd3, 32'h1);
    check("R9 core1 quiet", irq_o, 0);
  endtask

  task automatic t_auto;
    base = exp_cnt;
    wr(0, 1, 3'd6, 32'd3);
    wr(0, 1, 3'd4, base[31:0] + 32'd2);
    wr(0, 1, 3'd5, base[63:32]);
    wr(0, 1, 3'd2, 32'h7);
    ticks(2);
    rdw(0, 1, 3'd3, rd); check("R10 first match", rd, 1);
    rdw(0, 1, 3'd4, rd); check("R10 compare stepped", rd, base[31:0] + 32'd5);
    wr(0, 1, 3'd3, 32'h1);
    ticks(2);
    rdw(0, 1, 3'd3, rd); check("R10 no early repeat", rd, 0);
    ticks(1);
    rdw(0, 1, 3'd3, rd); check("R10 periodic repeat", rd, 1);
    check("R9 periodic irq", irq_o, 2'b01);
    rdw(0, 1, 3'd4, rd); check("R10 compare stepped again", rd, base[31:0] + 32'd8);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_count;
    t_load_carry;
    t_match;
    t_mask_bank;
    t_auto;
    finish_run;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule